// File: doc/BRIEF.md
# Spawn-Join Thread Dispatcher

This block moves an array of thread units between a serial mode and a parallel mode. In serial mode only unit 0 runs. A spawn command with a thread count n starts parallel mode. Every unit starts on the thread whose ID equals its own index. A unit whose index is n or more has nothing to do and joins at once.

When a running unit finishes a thread, it pulses its done line. In the same edge the dispatcher gives it the next ID from a shared counter. The counter starts at the number of units, and several units that finish together receive consecutive IDs in ascending unit order. A unit whose new ID is at or above n stops and counts as joined. Threads past the first wave therefore start as soon as any single unit frees up, without waiting for the whole wave to end.

When every unit has joined and no global-register broadcast is outstanding, the array returns to serial mode and raises a one-cycle completion pulse.

Top module: `thread_dispatcher`

## Requirements
- R1: After reset, and in every cycle of serial mode, `parallelMode` is 0 and `unitRun` equals 1 (only unit 0 runs), with unit 0 showing ID 0. `unitDone` has no effect in serial mode.
- R2: `spawnValid` sampled high in serial mode makes `parallelMode` 1 from the next cycle. In that cycle unit i shows ID i and runs exactly when i < `spawnCount`. `spawnValid` sampled in parallel mode is ignored.
- R3: At a spawn, units with index at or above n are not running. With n = 0 no unit runs, and the array goes back to serial mode without starting any thread.
- R4: A `unitDone` pulse from a running unit in parallel mode gives that unit a new ID in the next cycle. The unit keeps running if the new ID is below n and stops (joins) otherwise. A pulse from a unit that is not running has no effect.
- R5: IDs handed out after the spawn come from a counter that starts at the number of units. Each ID is issued once. Units that finish in the same cycle receive consecutive IDs, the lowest to the lowest unit index. No two running units ever show the same ID.
- R6: When all units have joined and `pendingBcast` is 0 in a cycle, the next cycle has `parallelMode` 0 and `joinDone` 1. `joinDone` lasts exactly one cycle.
- R7: While `pendingBcast` is nonzero, the array stays in parallel mode even when all units have joined.
- R8: The ID counter is cleared at join, so a later spawn again hands out IDs starting at the number of units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spawnValid | input | 1 | Spawn command (acted on in serial mode only) |
| spawnCount | input | CNT_W | Thread count n for the spawn |
| unitDone | input | NUM_UNITS | Per-unit pulse: current thread finished, request next ID |
| pendingBcast | input | PEND_W | Number of global-register writes not yet broadcast |
| parallelMode | output | 1 | 1 in parallel mode, 0 in serial mode |
| unitRun | output | NUM_UNITS | Per-unit run enable |
| unitTid | output | NUM_UNITS*(CNT_W+1) | Per-unit thread ID, unit i in bits [i*(CNT_W+1) +: CNT_W+1] |
| joinDone | output | 1 | One-cycle pulse on return to serial mode |

## Verification
Any wrong internal state shows at the ports one cycle after the edge that caused it. A counter that is off by any amount makes the next granted ID wrong in the cycle after a `unitDone` pulse. A wrong count of simultaneous requests shows up as duplicate or skipped IDs on the next grant. A wrong joined flag keeps `parallelMode` high after the last unit stops, or drops it early while a unit is still running. A counter left uncleared at join shows up at the first grant after the next spawn.

// File: rtl/thread_disp_pkg.sv
package thread_disp_pkg;
  typedef enum logic {MODE_SERIAL = 1'b0, MODE_PARALLEL = 1'b1} modeE;

  typedef struct packed {
    logic spawnLoad;  // load initial IDs and thread count
    logic grantEn;    // serve finished units from the ID counter
    logic finish;     // return every unit to the serial layout
  } ctrlStrobeT;
endpackage

// File: rtl/disp_ctrl.sv
module disp_ctrl
  import thread_disp_pkg::*;
#(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spawnValid,
  input  logic              allJoined,
  input  logic [PEND_W-1:0] pendingBcast,
  output ctrlStrobeT        strobe,
  output logic              parallelMode,
  output logic              joinDone
);
  modeE modeQ, modeD;
  logic joinDoneQ;

  always_comb begin
    strobe = '0;
    modeD  = modeQ;
    case (modeQ)
      MODE_SERIAL: begin
        if (spawnValid) begin
          strobe.spawnLoad = 1'b1;
          modeD = MODE_PARALLEL;
        end
      end
      default: begin
        if (allJoined && (pendingBcast == '0)) begin
          strobe.finish = 1'b1;
          modeD = MODE_SERIAL;
        end else begin
          strobe.grantEn = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= MODE_SERIAL;
      joinDoneQ <= 1'b0;
    end else begin
      modeQ     <= modeD;
      joinDoneQ <= strobe.finish;
    end
  end

  assign parallelMode = (modeQ == MODE_PARALLEL);
  assign joinDone     = joinDoneQ;
endmodule

// File: rtl/disp_datapath.sv
module disp_datapath
  import thread_disp_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int CNT_W     = 8,
  parameter int TID_W     = CNT_W + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobeT                 strobe,
  input  logic [CNT_W-1:0]           spawnCount,
  input  logic [NUM_UNITS-1:0]       unitDone,
  output logic [NUM_UNITS-1:0]       unitRun,
  output logic [NUM_UNITS*TID_W-1:0] unitTid,
  output logic                       allJoined
);
  localparam int RANK_W = $clog2(NUM_UNITS + 1);

  logic             runQ    [NUM_UNITS];
  logic             joinedQ [NUM_UNITS];
  logic [TID_W-1:0] tidQ    [NUM_UNITS];
  logic [TID_W-1:0] grantId [NUM_UNITS];
  logic [RANK_W-1:0] rank   [NUM_UNITS];
  logic [NUM_UNITS-1:0] req;
  logic [NUM_UNITS-1:0] joinedVec;
  logic [RANK_W-1:0] reqTotal;
  logic [TID_W-1:0] nextIdQ;
  logic [CNT_W-1:0] countQ;

  // Ascending-index ranking of simultaneous requests.
  always_comb begin
    reqTotal = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      rank[i]    = reqTotal;
      grantId[i] = nextIdQ + TID_W'(reqTotal);
      reqTotal   = reqTotal + RANK_W'(req[i]);
    end
  end

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    assign req[g]       = unitDone[g] & runQ[g];
    assign joinedVec[g] = joinedQ[g];
    assign unitRun[g]   = runQ[g];
    assign unitTid[g*TID_W +: TID_W] = tidQ[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tidQ[g]    <= '0;
        runQ[g]    <= (g == 0);
        joinedQ[g] <= 1'b0;
      end else if (strobe.finish) begin
        tidQ[g]    <= '0;
        runQ[g]    <= (g == 0);
        joinedQ[g] <= 1'b0;
      end else if (strobe.spawnLoad) begin
        tidQ[g]    <= TID_W'(g);
        runQ[g]    <= (TID_W'(g) < {1'b0, spawnCount});
        joinedQ[g] <= (TID_W'(g) >= {1'b0, spawnCount});
      end else if (strobe.grantEn && req[g]) begin
        tidQ[g]    <= grantId[g];
        runQ[g]    <= (grantId[g] < {1'b0, countQ});
        joinedQ[g] <= (grantId[g] >= {1'b0, countQ});
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextIdQ <= '0;
      countQ  <= '0;
    end else if (strobe.finish) begin
      nextIdQ <= '0;
      countQ  <= '0;
    end else if (strobe.spawnLoad) begin
      nextIdQ <= TID_W'(NUM_UNITS);
      countQ  <= spawnCount;
    end else if (strobe.grantEn) begin
      nextIdQ <= nextIdQ + TID_W'(reqTotal);
    end
  end

  assign allJoined = &joinedVec;
endmodule

// File: rtl/thread_dispatcher.sv
module thread_dispatcher
  import thread_disp_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int CNT_W     = 8,
  parameter int PEND_W    = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             spawnValid,
  input  logic [CNT_W-1:0]                 spawnCount,
  input  logic [NUM_UNITS-1:0]             unitDone,
  input  logic [PEND_W-1:0]                pendingBcast,
  output logic                             parallelMode,
  output logic [NUM_UNITS-1:0]             unitRun,
  output logic [NUM_UNITS*(CNT_W+1)-1:0]   unitTid,
  output logic                             joinDone
);
  localparam int TID_W = CNT_W + 1;

  ctrlStrobeT strobe;
  logic       allJoined;

  disp_ctrl #(.PEND_W(PEND_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .spawnValid   (spawnValid),
    .allJoined    (allJoined),
    .pendingBcast (pendingBcast),
    .strobe       (strobe),
    .parallelMode (parallelMode),
    .joinDone     (joinDone)
  );

  disp_datapath #(.NUM_UNITS(NUM_UNITS), .CNT_W(CNT_W), .TID_W(TID_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .spawnCount (spawnCount),
    .unitDone   (unitDone),
    .unitRun    (unitRun),
    .unitTid    (unitTid),
    .allJoined  (allJoined)
  );
endmodule

// File: rtl/thread_dispatcher_chk.sv
module thread_dispatcher_chk #(
  parameter int NUM_UNITS = 4,
  parameter int CNT_W     = 8,
  parameter int PEND_W    = 4
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           spawnValid,
  input logic [CNT_W-1:0]               spawnCount,
  input logic [NUM_UNITS-1:0]           unitDone,
  input logic [PEND_W-1:0]              pendingBcast,
  input logic                           parallelMode,
  input logic [NUM_UNITS-1:0]           unitRun,
  input logic [NUM_UNITS*(CNT_W+1)-1:0] unitTid,
  input logic                           joinDone
);
  localparam int TID_W = CNT_W + 1;
  logic [CNT_W-1:0] nSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nSeen <= '0;
    else if (!parallelMode && spawnValid) nSeen <= spawnCount;
  end

  p_serial_unit0_r1: assert property (@(posedge clk) disable iff (!rstN)
    !parallelMode |-> (unitRun == NUM_UNITS'(1)));

  p_spawn_enter_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!parallelMode && spawnValid) |=> (parallelMode && !joinDone));

  p_join_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    joinDone |-> (!parallelMode && $past(parallelMode)));

  p_join_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    joinDone |=> !joinDone);

  p_hold_pending_r7: assert property (@(posedge clk) disable iff (!rstN)
    (parallelMode && (pendingBcast != '0)) |=> parallelMode);

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_a
    p_tid_below_n_r4: assert property (@(posedge clk) disable iff (!rstN)
      (parallelMode && unitRun[i]) |-> (unitTid[i*TID_W +: TID_W] < {1'b0, nSeen}));
    for (genvar j = i + 1; j < NUM_UNITS; j++) begin : g_b
      p_unique_tid_r5: assert property (@(posedge clk) disable iff (!rstN)
        (parallelMode && unitRun[i] && unitRun[j]) |->
        (unitTid[i*TID_W +: TID_W] != unitTid[j*TID_W +: TID_W]));
    end
  end
endmodule

bind thread_dispatcher thread_dispatcher_chk #(
  .NUM_UNITS(NUM_UNITS), .CNT_W(CNT_W), .PEND_W(PEND_W)
) u_chk (
  .clk(clk), .rstN(rstN), .spawnValid(spawnValid), .spawnCount(spawnCount),
  .unitDone(unitDone), .pendingBcast(pendingBcast), .parallelMode(parallelMode),
  .unitRun(unitRun), .unitTid(unitTid), .joinDone(joinDone)
);

// File: tb/thread_dispatcher_tb.sv
module thread_dispatcher_tb;
  localparam int NU = 4;
  localparam int CW = 8;
  localparam int PW = 4;
  localparam int TW = CW + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spawnValid = 1'b0;
  logic [CW-1:0] spawnCount = '0;
  logic [NU-1:0] unitDone = '0;
  logic [PW-1:0] pendingBcast = '0;
  logic parallelMode, joinDone;
  logic [NU-1:0] unitRun;
  logic [NU*TW-1:0] unitTid;

  int checks = 0;
  int fails = 0;

  // Reference state, derived from the requirements.
  bit mPar, mDone;
  bit mRun [NU];
  bit mJoin [NU];
  int mTid [NU];
  int mNext, mN;

  always #4 clk = ~clk;

  thread_dispatcher #(.NUM_UNITS(NU), .CNT_W(CW), .PEND_W(PW)) u_dut (
    .clk(clk), .rstN(rstN), .spawnValid(spawnValid), .spawnCount(spawnCount),
    .unitDone(unitDone), .pendingBcast(pendingBcast), .parallelMode(parallelMode),
    .unitRun(unitRun), .unitTid(unitTid), .joinDone(joinDone)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic bit allJoinedM();
    for (int i = 0; i < NU; i++) if (!mJoin[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic void modelReset();
    mPar = 0; mDone = 0; mNext = 0; mN = 0;
    for (int i = 0; i < NU; i++) begin
      mRun[i] = (i == 0); mJoin[i] = 0; mTid[i] = 0;
    end
  endfunction

  function automatic void modelStep(bit sp, int n, logic [NU-1:0] dn, int pend);
    if (!mPar) begin
      mDone = 0;
      if (sp) begin
        mPar = 1; mN = n; mNext = NU;
        for (int i = 0; i < NU; i++) begin
          mTid[i] = i; mRun[i] = (i < n); mJoin[i] = !(i < n);
        end
      end
    end else if (allJoinedM() && pend == 0) begin
      modelReset();
      mDone = 1;
    end else begin
      mDone = 0;
      for (int i = 0; i < NU; i++) begin
        if (dn[i] && mRun[i]) begin
          mTid[i] = mNext; mNext++;
          mRun[i] = (mTid[i] < mN); mJoin[i] = !mRun[i];
        end
      end
    end
  endfunction

  task automatic compareAll(input string tag);
    check(parallelMode == mPar, tag, "parallelMode", int'(parallelMode), int'(mPar));
    check(joinDone == mDone, tag, "joinDone", int'(joinDone), int'(mDone));
    for (int i = 0; i < NU; i++) begin
      check(unitRun[i] == mRun[i], tag, $sformatf("unitRun[%0d]", i), int'(unitRun[i]), int'(mRun[i]));
      if (mRun[i])
        check(int'(unitTid[i*TW +: TW]) == mTid[i], tag, $sformatf("unitTid[%0d]", i),
              int'(unitTid[i*TW +: TW]), mTid[i]);
    end
  endtask

  // Check the outputs at the falling edge, then drive the next inputs.
  task automatic cycle(input bit sp, input int n, input logic [NU-1:0] dn,
                       input int pend, input string tag);
    @(negedge clk);
    compareAll(tag);
    spawnValid = sp; spawnCount = CW'(n); unitDone = dn; pendingBcast = PW'(pend);
    modelStep(sp, n, dn, pend);
  endtask

  task automatic episode(input int n, input int doneProb, input int pendProb, input string tag);
    int guard = 0;
    cycle(1'b1, n, '0, 0, tag);
    while ((mPar || !mDone) && guard < 3000) begin
      logic [NU-1:0] dn;
      bit sp;
      int pend;
      for (int i = 0; i < NU; i++) dn[i] = ($urandom_range(99) < doneProb);
      pend = ($urandom_range(99) < pendProb) ? int'($urandom_range(1, 15)) : 0;
      sp = ($urandom_range(99) < 10) && mPar; // spawn during parallel: R2 ignore
      cycle(sp, int'($urandom_range(0, 20)), dn, pend, tag);
      guard++;
    end
    cycle(1'b0, 0, '0, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog: got no end of test, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state, and unitDone in serial mode changes nothing.
    cycle(1'b0, 0, '0, 0, "R1");
    cycle(1'b0, 0, '1, 0, "R1");
    cycle(1'b0, 0, '1, 0, "R1");

    // R3: zero threads, every unit joins immediately.
    episode(0, 50, 0, "R3");
    // R3: fewer threads than units.
    episode(3, 40, 0, "R3");

    // R2: spawn, then a second spawn in parallel mode is ignored.
    cycle(1'b1, 9, '0, 0, "R2");
    cycle(1'b1, 2, '0, 0, "R2");
    cycle(1'b1, 1, '0, 0, "R2");
    // R5: all units finish together, ascending IDs from NU.
    cycle(1'b0, 0, '1, 0, "R5");
    cycle(1'b0, 0, 4'b1010, 0, "R5");
    // R4: done from non-running unit has no effect once joined.
    cycle(1'b0, 0, '1, 0, "R4");
    cycle(1'b0, 0, '1, 0, "R4");
    // R7: all joined but broadcasts pending.
    for (int k = 0; k < 5; k++) cycle(1'b0, 0, '1, 3, "R7");
    // R6: release, join pulse.
    cycle(1'b0, 0, '0, 0, "R6");
    cycle(1'b0, 0, '0, 0, "R6");
    cycle(1'b0, 0, '0, 0, "R6");

    // R8: counter restarts after join.
    cycle(1'b1, 6, '0, 0, "R8");
    cycle(1'b0, 0, 4'b0100, 0, "R8");
    cycle(1'b0, 0, 4'b0001, 0, "R8");
    episode(5, 30, 0, "R8");

    // R4: constrained random episodes.
    for (int e = 0; e < 60; e++)
      episode(int'($urandom_range(0, 30)), int'($urandom_range(10, 60)), 20, "R4");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule